// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs. It produces the management clock (MDC) and drives or samples the single bidirectional data line through three separate pins: an output value, an output enable and an input. A host issues one command at a time. Each command has an operation code, a 5-bit PHY address, a register number or 21-bit extended address, and write data. The block builds the serial frames, shifts them out, and returns read data with a one-cycle completion pulse.

Short-address (Clause 22) accesses use one frame. Extended-address (Clause 45) accesses use two frames. The first frame loads the 16-bit register address into the selected device. The second frame reads or writes that register. On reads, the block checks the turnaround bit that the PHY drives. If the PHY fails to pull it low, the block clocks out 32 dummy bits and reports all ones. A configuration mask lets selected PHYs with faulty turnaround skip that check.

Bit timing is set by parameters counted in system clock cycles. `HALF_CYC` sets the low phase of every bit and the high phase of driven bits. `RDHI_CYC` sets a longer high phase for bits the PHY drives. The reset is asynchronous and active-low, and is expected to be released synchronously outside the block.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low, and whenever no command is in progress, `mdc`, `mdio_oe`, `busy` and `done` are 0. A reset during a frame aborts it at once.
- R2: Every frame begins with 32 driven ones. Then come a 2-bit start code and a 2-bit opcode. A short-address read sends 01 10 and a short-address write sends 01 01. `cmd_op` encoding: 00 short read, 01 short write, 10 extended read, 11 extended write.
- R3: After the opcode, the block sends the 5-bit PHY address and then a 5-bit register field, both MSB first. For short accesses the register field is `cmd_addr[4:0]`.
- R4: A write frame continues with a driven turnaround of 1 then 0, then 16 data bits MSB first. It ends with one clock with the line released, for 65 MDC pulses in total.
- R5: An extended access first sends an address frame: start 00, opcode 00, register field `cmd_addr[20:16]`, payload `cmd_addr[15:0]`, in write-frame form. The main frame follows, with start 00, opcode 11 for a read or 01 for a write, and the same PHY and device fields.
- R6: A read frame releases the line after the 46 header bits and samples one turnaround bit. When that bit is 0, the block samples 16 data bits MSB first and gives one more released clock, for 64 pulses in total. The result appears on `rd_data`.
- R7: If the sampled turnaround bit is 1 and `ta_ignore_mask[phy]` is 0, the block clocks 32 more released bits, for 79 pulses in total, and `rd_data` becomes 16'hFFFF.
- R8: If `ta_ignore_mask[phy]` is 1, a turnaround bit of 1 is ignored and the read completes normally. Mask bits of other PHYs have no effect.
- R9: MDC low phases last `HALF_CYC` cycles. High phases last `HALF_CYC` cycles while the master drives the line and `RDHI_CYC` cycles while it is released. The line input is captured as MDC falls. Output data changes only while MDC is low.
- R10: A command is taken only when `busy` is 0, and `busy` rises in the next cycle. `cmd_valid` while busy is ignored. `done` is a one-cycle pulse after the last frame, with `busy` already low. For reads, `rd_data` is valid with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | Operation: 00 short read, 01 short write, 10 extended read, 11 extended write |
| cmd_phy | input | 5 | PHY address |
| cmd_addr | input | 21 | Register number in [4:0], or extended address (device in [20:16]) |
| cmd_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY turnaround check bypass |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line output value |
| mdio_oe | output | 1 | Line output enable |
| mdio_i | input | 1 | Line input |

## Verification
The vector table covers all four operation codes and uses PHY addresses at both ends of the range. Some payloads have asymmetric bit patterns, so a reversed or shifted field shows up as a mismatch. Each MDC pulse is compared with the expected bit or released state, so a wrong start code, opcode or field order is caught on its own pulse. Reads are tried with a good turnaround, a bad turnaround with the mask bit clear, a bad turnaround with the mask bit set, and a bad turnaround on an extended read. These four cases separate normal completion, the 32-bit flush with all-ones data, and a mask lookup on the wrong PHY. Directed tests cover a command offered while busy and a reset in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DAT_W      = 16;
  localparam int EXT_W      = 21;
  localparam int FLUSH_BITS = 32;
  localparam int HDR_BITS   = PRE_BITS + 4 + PHY_W + REG_W;
  localparam int TX_BITS    = HDR_BITS + 2 + DAT_W;
  localparam int WR_LAST    = TX_BITS;
  localparam int RD_LAST    = HDR_BITS + DAT_W + 1;
  localparam int ERR_LAST   = HDR_BITS + FLUSH_BITS;
  localparam int IDX_W      = $clog2(ERR_LAST + 1);

  localparam logic [1:0] OP_SHORT_RD = 2'b00;
  localparam logic [1:0] OP_SHORT_WR = 2'b01;
  localparam logic [1:0] OP_EXT_RD   = 2'b10;
  localparam logic [1:0] OP_EXT_WR   = 2'b11;

  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_MAIN} mstate_t;
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int HALF_CYC = 63,
  parameter int RDHI_CYC = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_hi,
  output logic mdc,
  output logic bit_end
);
  localparam int MAXC = (RDHI_CYC > HALF_CYC) ? RDHI_CYC : HALF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] RDHI_M1 = CW'(RDHI_CYC - 1);

  logic [CW-1:0] cnt, cnt_n, lim;
  logic          hi, hi_n;

  always_comb begin
    lim     = (hi && long_hi) ? RDHI_M1 : HALF_M1;
    cnt_n   = cnt;
    hi_n    = hi;
    bit_end = 1'b0;
    if (!run) begin
      cnt_n = '0;
      hi_n  = 1'b0;
    end else if (cnt == lim) begin
      cnt_n = '0;
      if (hi) begin
        hi_n    = 1'b0;
        bit_end = 1'b1;
      end else begin
        hi_n = 1'b1;
      end
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else begin
      cnt <= cnt_n;
      hi  <= hi_n;
    end
  end

  assign mdc = hi;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 63,
  parameter int RDHI_CYC = 88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic             ign_ta,
  input  logic [3:0]       st_op,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regf,
  input  logic [DAT_W-1:0] payload,
  input  logic             mdio_i,
  output logic             fr_done,
  output logic [DAT_W-1:0] rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] TX_IDX  = IDX_W'(TX_BITS);
  localparam logic [IDX_W-1:0] WR_IDX  = IDX_W'(WR_LAST);
  localparam logic [IDX_W-1:0] RD_IDX  = IDX_W'(RD_LAST);
  localparam logic [IDX_W-1:0] ERR_IDX = IDX_W'(ERR_LAST);

  logic               act, act_n, rd, rd_n, ign, ign_n, err, err_n, dn_n;
  logic [IDX_W-1:0]   idx, idx_n, drive_lim, last_idx;
  logic [TX_BITS-1:0] tx, tx_n;
  logic [DAT_W-1:0]   rx, rx_n;
  logic               oe, bit_end;

  assign drive_lim = rd ? HDR_IDX : TX_IDX;
  assign last_idx  = rd ? (err ? ERR_IDX : RD_IDX) : WR_IDX;
  assign oe        = act && (idx < drive_lim);

  mdio_bit_timer #(.HALF_CYC(HALF_CYC), .RDHI_CYC(RDHI_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(act), .long_hi(!oe),
    .mdc(mdc), .bit_end(bit_end)
  );

  always_comb begin
    act_n = act; rd_n = rd; ign_n = ign; err_n = err;
    idx_n = idx; tx_n = tx; rx_n = rx; dn_n = 1'b0;
    if (start && !act) begin
      act_n = 1'b1;
      rd_n  = is_read;
      ign_n = ign_ta;
      err_n = 1'b0;
      idx_n = '0;
      tx_n  = {{PRE_BITS{1'b1}}, st_op, phy, regf, 2'b10, payload};
      rx_n  = '0;
    end else if (act && bit_end) begin
      tx_n  = tx << 1;
      idx_n = idx + 1'b1;
      if (rd && idx == HDR_IDX && mdio_i && !ign)
        err_n = 1'b1;
      if (rd && !err && idx > HDR_IDX && idx < RD_IDX)
        rx_n = {rx[DAT_W-2:0], mdio_i};
      if (idx == last_idx) begin
        act_n = 1'b0;
        dn_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; rd <= 1'b0; ign <= 1'b0; err <= 1'b0;
      idx <= '0; tx <= '0; rx <= '0; fr_done <= 1'b0;
    end else begin
      act <= act_n; rd <= rd_n; ign <= ign_n; err <= err_n;
      idx <= idx_n; tx <= tx_n; rx <= rx_n; fr_done <= dn_n;
    end
  end

  assign rdata   = err ? {DAT_W{1'b1}} : rx;
  assign mdio_oe = oe;
  assign mdio_o  = oe & tx[TX_BITS-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 63,
  parameter int RDHI_CYC = 88
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [4:0]  cmd_phy,
  input  logic [20:0] cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [31:0] ta_ignore_mask,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mstate_t          st, st_n;
  logic [1:0]       op_q, op_n;
  logic [PHY_W-1:0] phy_q, phy_n;
  logic [EXT_W-1:0] adr_q, adr_n;
  logic [DAT_W-1:0] wd_q, wd_n, rdat_q, rdat_n, fr_rdata, f_pay;
  logic             go, go_n, dn_n, fr_done, f_rd, is_ext, rd_op;
  logic [3:0]       f_stop;
  logic [REG_W-1:0] f_reg;

  assign is_ext = op_q[1];
  assign rd_op  = ~op_q[0];

  always_comb begin
    if (st == M_ADDR) begin
      f_stop = 4'b0000;
      f_reg  = adr_q[EXT_W-1:DAT_W];
      f_pay  = adr_q[DAT_W-1:0];
      f_rd   = 1'b0;
    end else begin
      f_stop = is_ext ? {2'b00, rd_op ? 2'b11 : 2'b01}
                      : {2'b01, rd_op ? 2'b10 : 2'b01};
      f_reg  = is_ext ? adr_q[EXT_W-1:DAT_W] : adr_q[REG_W-1:0];
      f_pay  = wd_q;
      f_rd   = rd_op;
    end
  end

  mdio_frame_seq #(.HALF_CYC(HALF_CYC), .RDHI_CYC(RDHI_CYC)) u_fr (
    .clk(clk), .rst_n(rst_n), .start(go), .is_read(f_rd),
    .ign_ta(ta_ignore_mask[phy_q]), .st_op(f_stop), .phy(phy_q),
    .regf(f_reg), .payload(f_pay), .mdio_i(mdio_i),
    .fr_done(fr_done), .rdata(fr_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_comb begin
    st_n = st; op_n = op_q; phy_n = phy_q; adr_n = adr_q; wd_n = wd_q;
    rdat_n = rdat_q; go_n = 1'b0; dn_n = 1'b0;
    case (st)
      M_IDLE: if (cmd_valid) begin
        op_n  = cmd_op;
        phy_n = cmd_phy;
        adr_n = cmd_addr;
        wd_n  = cmd_wdata;
        st_n  = cmd_op[1] ? M_ADDR : M_MAIN;
        go_n  = 1'b1;
      end
      M_ADDR: if (fr_done) begin
        st_n = M_MAIN;
        go_n = 1'b1;
      end
      M_MAIN: if (fr_done) begin
        st_n = M_IDLE;
        dn_n = 1'b1;
        if (rd_op) rdat_n = fr_rdata;
      end
      default: st_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; op_q <= '0; phy_q <= '0; adr_q <= '0; wd_q <= '0;
      rdat_q <= '0; go <= 1'b0; done <= 1'b0;
    end else begin
      st <= st_n; op_q <= op_n; phy_q <= phy_n; adr_q <= adr_n; wd_q <= wd_n;
      rdat_q <= rdat_n; go <= go_n; done <= dn_n;
    end
  end

  assign busy    = (st != M_IDLE);
  assign rd_data = rdat_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  // R1: line and clock quiet whenever no command is in progress
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  // R10: completion pulse lasts a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy already low when done fires
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: an offered command is taken while idle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  // R9: output value and enable hold while MDC stays high
  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int HC = 3;
  localparam int RH = 5;
  localparam int NV = 7;

  // {op, phy, addr, wdata, phy response, ta value, own mask bit}
  localparam logic [61:0] VEC [NV] = '{
    {2'b01, 5'd1,  21'h000003, 16'hA5C3, 16'h0000, 1'b0, 1'b0},
    {2'b00, 5'd31, 21'h00001F, 16'h0000, 16'h1234, 1'b0, 1'b0},
    {2'b11, 5'd5,  21'h1ABEEF, 16'h0F0F, 16'h0000, 1'b0, 1'b0},
    {2'b10, 5'd0,  21'h010001, 16'h0000, 16'h8001, 1'b0, 1'b0},
    {2'b00, 5'd7,  21'h000002, 16'h0000, 16'h5A5A, 1'b1, 1'b0},
    {2'b00, 5'd7,  21'h000002, 16'h0000, 16'h5555, 1'b1, 1'b1},
    {2'b10, 5'd9,  21'h030040, 16'h0000, 16'hC0DE, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [4:0] cmd_phy;
  logic [20:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic [31:0] ta_ignore_mask;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i;

  always #2 clk = ~clk;

  mdio_master #(.HALF_CYC(HC), .RDHI_CYC(RH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_phy(cmd_phy), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ta_ignore_mask(ta_ignore_mask), .busy(busy), .done(done),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nr = 0;
  int rise_t = 0;
  int fall_t = 0;
  logic [1:0] cap [200];
  int wid [200];
  int lw [200];

  logic [1:0] c_op;
  logic [4:0] c_phy;
  logic [20:0] c_addr;
  logic [15:0] c_wd, c_resp;
  logic c_ta;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] fbit(input logic rd, input logic [3:0] so,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] pay, input int k);
    if (k < 32) return 2'd1;
    if (k < 36) return {1'b0, so[35-k]};
    if (k < 41) return {1'b0, p[40-k]};
    if (k < 46) return {1'b0, r[45-k]};
    if (rd) return 2'd2;
    if (k == 46) return 2'd1;
    if (k == 47) return 2'd0;
    if (k < 64) return {1'b0, pay[63-k]};
    return 2'd2;
  endfunction

  function automatic logic [1:0] op_bit(input int n);
    logic ext = c_op[1];
    logic rd = ~c_op[0];
    logic [3:0] so;
    int k = n;
    if (ext) begin
      if (n < 65) return fbit(1'b0, 4'b0000, c_phy, c_addr[20:16], c_addr[15:0], n);
      k = n - 65;
      so = {2'b00, rd ? 2'b11 : 2'b01};
      return fbit(rd, so, c_phy, c_addr[20:16], c_wd, k);
    end
    so = {2'b01, rd ? 2'b10 : 2'b01};
    return fbit(rd, so, c_phy, c_addr[4:0], c_wd, k);
  endfunction

  function automatic logic resp_bit(input int n);
    int k = n - (c_op[1] ? 65 : 0);
    if (c_op[0]) return 1'b1;
    if (k == 46) return c_ta;
    if (k > 46 && k < 63) return c_resp[62-k];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (nr < 200) begin
      cap[nr] = mdio_oe ? {1'b0, mdio_o} : 2'd2;
      lw[nr] = cyc - fall_t;
    end
    rise_t = cyc;
    mdio_i = resp_bit(nr);
    nr = nr + 1;
  end

  always @(negedge mdc) begin
    if (nr > 0 && nr <= 200) wid[nr-1] = cyc - rise_t;
    fall_t = cyc;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] p,
                       input logic [20:0] a, input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_phy = p; cmd_addr = a; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  initial begin
    int ok, expn, bad;
    logic expect_err;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_phy = '0; cmd_addr = '0;
    cmd_wdata = '0; ta_ignore_mask = '0; mdio_i = 1'b1;
    c_op = 2'b01; c_phy = '0; c_addr = '0; c_wd = '0; c_resp = '0; c_ta = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!mdc && !mdio_oe && !busy && !done, "R1 reset state",
        {mdc, mdio_oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done, "R1 idle after reset",
        {mdc, mdio_oe, busy, done}, 0);

    for (int v = 0; v < NV; v++) begin
      {c_op, c_phy, c_addr, c_wd, c_resp, c_ta, ta_ignore_mask[0]} = {VEC[v][61:1], 1'b0};
      ta_ignore_mask = VEC[v][0] ? (32'h1 << c_phy) : ~(32'h1 << c_phy);
      expect_err = c_ta && !VEC[v][0];
      nr = 0;
      issue(c_op, c_phy, c_addr, c_wd);
      chk(busy, "R10 busy after accept", busy, 1);
      wait_done(ok);
      chk(ok == 1, "R10 done reached", ok, 1);
      expn = (c_op[1] ? 65 : 0) + (c_op[0] ? 65 : (expect_err ? 79 : 64));
      chk(nr == expn, c_op[0] ? "R4/R5 pulse count" :
          (expect_err ? "R7 flush pulse count" : "R6 read pulse count"), nr, expn);
      bad = 0;
      for (int n = 0; n < nr && n < 200; n++) if (cap[n] !== op_bit(n)) bad++;
      chk(bad == 0, "R2/R3/R5 frame bits", bad, 0);
      if (!c_op[0]) begin
        chk(!busy, "R10 busy low with done", busy, 0);
        chk(rd_data == (expect_err ? 16'hFFFF : c_resp),
            expect_err ? "R7 error data" : (c_ta ? "R8 masked ta" : "R6 read data"),
            rd_data, expect_err ? 16'hFFFF : c_resp);
      end
      chk(wid[0] == HC, "R9 driven high width", wid[0], HC);
      chk(lw[1] == HC, "R9 low width", lw[1], HC);
      chk(wid[(c_op[1] ? 65 : 0) + (c_op[0] ? 64 : 46)] == RH,
          "R9 released high width", wid[(c_op[1] ? 65 : 0) + (c_op[0] ? 64 : 46)], RH);
      @(negedge clk);
      chk(!done, "R10 done single cycle", done, 0);
    end

    // R10: command offered while busy is ignored
    c_op = 2'b01; c_phy = 5'd3; c_addr = 21'h00011; c_wd = 16'h8421;
    ta_ignore_mask = '0;
    nr = 0;
    issue(c_op, c_phy, c_addr, c_wd);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_phy = 5'd12; cmd_addr = 21'h5;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(ok);
    repeat (200) @(negedge clk);
    chk(nr == 65 && !busy, "R10 busy command ignored", nr, 65);
    bad = 0;
    for (int n = 0; n < 65; n++) if (cap[n] !== op_bit(n)) bad++;
    chk(bad == 0, "R10 frame unchanged", bad, 0);

    // R1: reset in the middle of a frame
    nr = 0;
    issue(2'b01, 5'd2, 21'h4, 16'hFFFF);
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mdc && !mdio_oe && !busy, "R1 abort on reset", {mdc, mdio_oe, busy}, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy, "R1 stays idle", {mdc, mdio_oe, busy}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule